// File: doc/BRIEF.md
# Configuration Address Translation Port

This block sits between a bus master and the configuration request path of a host bridge. The master sees two 4 KiB little-endian windows, chosen by a select input. The first window holds one 32-bit address word. The master reads it back unchanged, and it can write it one byte lane at a time. The second window is the data path. Each access there turns the stored address word, together with the low bits of the access offset, into a single configuration request on a simple downstream interface. That request carries a bus/device/function/register address and byte enables.

The stored word can take three forms, and two of its bits pick the form. When bit 31 is set, the word passes through as it is, with offset bits 1:0 merged in. When bit 31 is clear and bit 0 is set, the word is treated as an already-encoded type-1 address: its low three bits are replaced by offset bits 2:0. When both bits are clear, the word is a type-0 word in select-line style. The lowest set bit among bits 31..11 gives the device number, and the function and register fields are repacked into a type-0 address. If no select bit is set there is no target, so reads return all ones and writes are dropped.

Only one access is in flight at a time. The master holds its request until the block raises ready for one cycle. Ready stays low while a downstream request is outstanding.

Top module: `cfgx_port`

## Requirements
- R1: After reset the address word reads as 0, `cfg_valid` is low and `host_ready` is low.
- R2: Writes to the address window (`host_win`=0) update only the byte lanes enabled by size and offset, and a read returns the full stored word. A write returns read data 0.
- R3: When stored bit 31 is 1, a data-window access issues `cfg_addr` = stored word OR offset[1:0].
- R4: When stored bit 31 is 0 and bit 0 is 1, `cfg_addr` = {stored[31:3], offset[2:0]}.
- R5: When stored bits 31 and 0 are both 0, `cfg_addr[15:11]` is the index (11..30) of the lowest set bit in stored[31:11], and `cfg_addr[31:16]` is 0.
- R6: In the type-0 form, `cfg_addr[10:8]` = stored[10:8], `cfg_addr[7:3]` = stored[7:3] and `cfg_addr[2:0]` = offset[2:0].
- R7: In the type-0 form with stored[31:11] all zero, no downstream request is issued. A read returns 0xFFFFFFFF, and a write completes with no effect.
- R8: Size code 0/1/2 means 1/2/4 bytes. `cfg_be` has one bit set per byte from offset[1:0] upward, little-endian.
- R9: An access with size code 3, or one whose bytes pass beyond the 4-byte word, completes with `host_err`=1 and read data 0. It issues no downstream request and leaves the address word unchanged.
- R10: While a request is outstanding, `cfg_valid` stays high and `cfg_addr` stays stable until `cfg_done`. `host_ready` rises for one cycle exactly one cycle after `cfg_done`, and never while `cfg_valid` is high. An access that needs no downstream request gets ready on the cycle after it is accepted.
- R11: `cfg_write` follows `host_write`, and `cfg_wdata` carries `host_wdata` lane-aligned. A data-window read returns `cfg_rdata` as sampled with `cfg_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Access request, held until ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_win | input | 1 | 0 = address window, 1 = data window |
| host_off | input | OFF_W | Byte offset inside the window |
| host_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| host_wdata | input | 32 | Write data, lane-aligned |
| host_ready | output | 1 | One-cycle completion strobe |
| host_rdata | output | 32 | Read data, valid with ready |
| host_err | output | 1 | Access rejected, valid with ready |
| cfg_valid | output | 1 | Downstream configuration request |
| cfg_write | output | 1 | Downstream direction |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Downstream write data |
| cfg_done | input | 1 | Downstream completion strobe |
| cfg_rdata | input | 32 | Downstream read data, valid with done |

## Verification
The bench tries every decode form against words that contain stray bits. A design that checked bit 0 before bit 31 would mistranslate pass-through words with bit 0 set. One that took the highest select bit, or numbered the device from bit 11 instead of bit 0, would put the wrong value into bits 15:11. Empty select fields, unaligned widths and illegal sizes are checked for downstream silence, all-ones or error data, and an untouched address word. A design that leaked a request or altered the word would be caught there. Downstream latency is varied so that a ready raised early, late or for two cycles shows up as a per-clock mismatch against the bench model.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_RESP  = 2'd2
   } cfgx_state_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   localparam int unsigned CFG_W    = 32;
   localparam int unsigned CFG_LANES = CFG_W / 8;
   localparam int unsigned DEV_LSB  = 11;

endpackage

// File: rtl/cfgx_lane_decode.sv
module cfgx_lane_decode
   import cfgx_pkg::*;
#(
   parameter int unsigned LANES = CFG_LANES,
   localparam int unsigned LW   = $clog2(LANES)
) (
   input  logic [1:0]       size,
   input  logic [LW-1:0]    off_lo,
   output logic [LANES-1:0] be,
   output logic             bad
);

   initial begin
      assert (LANES == 4) else $error("cfgx_lane_decode: four lanes expected");
   end

   logic [3:0] nbytes;
   logic [3:0] span_end;

   always_comb begin
      unique case (size)
         SZ_BYTE: nbytes = 4'd1;
         SZ_HALF: nbytes = 4'd2;
         SZ_WORD: nbytes = 4'd4;
         default: nbytes = 4'd0;
      endcase
      span_end = 4'(off_lo) + nbytes;
   end

   assign bad = (nbytes == 4'd0) || (span_end > 4'(LANES));

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign be[b] = !bad && (4'(b) >= 4'(off_lo)) && (4'(b) < span_end);
   end

endmodule

// File: rtl/cfgx_lsb_find.sv
module cfgx_lsb_find #(
   parameter int unsigned W  = 21,
   localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);

   initial begin
      assert (W >= 2) else $error("cfgx_lsb_find: width too small");
   end

   logic [W:0]   seen;
   logic [W-1:0] first;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < W; i++) begin : g_chain
      assign first[i]  = vec[i] & ~seen[i];
      assign seen[i+1] = seen[i] | vec[i];
   end

   always_comb begin
      idx = '0;
      for (int k = 0; k < W; k++) begin
         if (first[k]) idx = idx | IW'(k);
      end
   end

   assign found = seen[W];

   always_comb begin
      if (found && !$isunknown(vec)) begin
         AST_LSB_FIRST: assert (vec[idx] && ((vec & ((W'(1) << idx) - W'(1))) == '0)); // R5
      end
   end

endmodule

// File: rtl/cfgx_addr_xlate.sv
module cfgx_addr_xlate
   import cfgx_pkg::*;
(
   input  logic [CFG_W-1:0] word,
   input  logic [2:0]       off_lo,
   output logic [CFG_W-1:0] xaddr,
   output logic             no_dev
);

   localparam int unsigned SEL_W = CFG_W - DEV_LSB;
   localparam int unsigned IW    = $clog2(SEL_W);

   logic          sel_found;
   logic [IW-1:0] sel_idx;
   logic [4:0]    dev_num;
   logic          pass_mode;
   logic          t1_mode;

   cfgx_lsb_find #(.W(SEL_W)) i_find (
      .vec   (word[CFG_W-1:DEV_LSB]),
      .found (sel_found),
      .idx   (sel_idx)
   );

   assign dev_num   = 5'(sel_idx) + 5'(DEV_LSB);
   assign pass_mode = word[CFG_W-1];
   assign t1_mode   = !pass_mode && word[0];

   always_comb begin
      if (pass_mode) begin
         xaddr = word | {30'd0, off_lo[1:0]};
      end else if (t1_mode) begin
         xaddr = {word[CFG_W-1:3], off_lo};
      end else begin
         xaddr = {16'd0, dev_num, word[10:8], word[7:3], off_lo};
      end
   end

   assign no_dev = !pass_mode && !t1_mode && !sel_found;

endmodule

// File: rtl/cfgx_addr_reg.sv
module cfgx_addr_reg
   import cfgx_pkg::*;
#(
   parameter int unsigned LANES = CFG_LANES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [LANES-1:0]   be,
   input  logic [8*LANES-1:0] wdata,
   output logic [8*LANES-1:0] q
);

   for (genvar b = 0; b < LANES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[8*b +: 8] <= 8'd0;
         end else if (we && be[b]) begin
            q[8*b +: 8] <= wdata[8*b +: 8];
         end
      end
   end

endmodule

// File: rtl/cfgx_port.sv
module cfgx_port
   import cfgx_pkg::*;
#(
   parameter int unsigned OFF_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_valid,
   input  logic             host_write,
   input  logic             host_win,
   input  logic [OFF_W-1:0] host_off,
   input  logic [1:0]       host_size,
   input  logic [31:0]      host_wdata,
   output logic             host_ready,
   output logic [31:0]      host_rdata,
   output logic             host_err,
   output logic             cfg_valid,
   output logic             cfg_write,
   output logic [31:0]      cfg_addr,
   output logic [3:0]       cfg_be,
   output logic [31:0]      cfg_wdata,
   input  logic             cfg_done,
   input  logic [31:0]      cfg_rdata
);

   initial begin
      assert (OFF_W >= 3 && OFF_W <= 16) else $error("cfgx_port: OFF_W out of range");
   end

   cfgx_state_e       st;
   logic [CFG_W-1:0]  word_q;
   logic [3:0]        be_c;
   logic              bad_c;
   logic [CFG_W-1:0]  xaddr_c;
   logic              no_dev_c;
   logic              accept;
   logic              reg_we;
   logic [31:0]       rsp_data;
   logic              rsp_err;
   logic              unused_off;

   assign unused_off = ^host_off[OFF_W-1:3];

   cfgx_lane_decode i_lanes (
      .size   (host_size),
      .off_lo (host_off[1:0]),
      .be     (be_c),
      .bad    (bad_c)
   );

   cfgx_addr_xlate i_xlate (
      .word   (word_q),
      .off_lo (host_off[2:0]),
      .xaddr  (xaddr_c),
      .no_dev (no_dev_c)
   );

   assign accept = (st == ST_IDLE) && host_valid;
   assign reg_we = accept && !host_win && host_write && !bad_c;

   cfgx_addr_reg i_word (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .be    (be_c),
      .wdata (host_wdata),
      .q     (word_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cfg_write <= 1'b0;
         cfg_addr  <= '0;
         cfg_be    <= '0;
         cfg_wdata <= '0;
         rsp_data  <= '0;
         rsp_err   <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (host_valid) begin
                  rsp_err  <= 1'b0;
                  rsp_data <= '0;
                  if (bad_c) begin
                     rsp_err <= 1'b1;
                     st      <= ST_RESP;
                  end else if (!host_win) begin
                     if (!host_write) rsp_data <= word_q;
                     st <= ST_RESP;
                  end else if (no_dev_c) begin
                     if (!host_write) rsp_data <= '1;
                     st <= ST_RESP;
                  end else begin
                     cfg_write <= host_write;
                     cfg_addr  <= xaddr_c;
                     cfg_be    <= be_c;
                     cfg_wdata <= host_wdata;
                     st        <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               if (cfg_done) begin
                  rsp_data <= cfg_write ? '0 : cfg_rdata;
                  st       <= ST_RESP;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign cfg_valid  = (st == ST_ISSUE);
   assign host_ready = (st == ST_RESP);
   assign host_rdata = rsp_data;
   assign host_err   = rsp_err;

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid && !cfg_done |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_be)); // R10
   AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid && cfg_done |=> host_ready); // R10
   AST_READY_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> !host_ready); // R10
   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |=> !host_ready); // R10
   AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      accept && bad_c |=> !cfg_valid && host_err && $stable(word_q)); // R9
   AST_BE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> (cfg_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'h6, 4'hC, 4'hF})); // R8
   AST_T0_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid && !word_q[31] && !word_q[0] |-> cfg_addr[31:16] == 16'd0); // R5
   AST_NODEV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      accept && host_win && !bad_c && word_q[31:11] == '0 && !word_q[0] |=> !cfg_valid); // R7

endmodule

// File: tb/test_cfgx_port.sv
module test_cfgx_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_valid = 1'b0;
   logic        host_write = 1'b0;
   logic        host_win = 1'b0;
   logic [11:0] host_off = '0;
   logic [1:0]  host_size = '0;
   logic [31:0] host_wdata = '0;
   logic        host_ready;
   logic [31:0] host_rdata;
   logic        host_err;
   logic        cfg_valid;
   logic        cfg_write;
   logic [31:0] cfg_addr;
   logic [3:0]  cfg_be;
   logic [31:0] cfg_wdata;
   logic        cfg_done = 1'b0;
   logic [31:0] cfg_rdata = '0;

   int n_checks = 0;
   int n_fails  = 0;
   logic [31:0] model_word = '0;

   always #4 clk = ~clk;

   cfgx_port #(.OFF_W(12)) i_cfgx_port (.*);

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_addr(input logic [31:0] w, input int off);
      logic [31:0] r;
      int dev;
      if (w[31]) return w | 32'(off % 4);
      if (w[0]) return (w & ~32'd7) | 32'(off % 8);
      dev = -1;
      for (int k = 31; k >= 11; k--) if (w[k]) dev = k;
      r = 32'(dev) << 11;
      r = r | (32'((w >> 8) % 8) << 8) | (w & 32'hF8) | 32'(off % 8);
      return r;
   endfunction

   function automatic bit ref_nodev(input logic [31:0] w);
      return !w[31] && !w[0] && ((w >> 11) == 0);
   endfunction

   function automatic int nbytes(input logic [1:0] sz);
      return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
   endfunction

   function automatic logic [3:0] ref_be(input int off, input logic [1:0] sz);
      logic [3:0] b = '0;
      for (int i = 0; i < 4; i++) if (i >= off % 4 && i < off % 4 + nbytes(sz)) b[i] = 1'b1;
      return b;
   endfunction

   // One access; per-clock comparison of ready and request against the model.
   task automatic access(input string req, input bit win, input bit wr, input int off,
                         input logic [1:0] sz, input logic [31:0] wd, input int lat,
                         input logic [31:0] dn_data);
      bit bad, exp_dn, seen_dn;
      int exp_rdy, cnt;
      logic [31:0] exp_rd;
      logic [31:0] exp_addr;
      bad = (nbytes(sz) == 0) || (off % 4 + nbytes(sz) > 4);
      exp_dn = win && !bad && !ref_nodev(model_word);
      exp_addr = ref_addr(model_word, off);
      exp_rd = 32'd0;
      if (!bad && !wr) exp_rd = !win ? model_word : (exp_dn ? dn_data : 32'hFFFF_FFFF);
      exp_rdy = exp_dn ? 0 : 1;
      cnt = 0;
      seen_dn = 0;
      @(negedge clk);
      host_valid = 1'b1; host_write = wr; host_win = win;
      host_off = 12'(off); host_size = sz; host_wdata = wd;
      for (int it = 1; it < 60; it++) begin
         @(negedge clk);
         cfg_done = 1'b0;
         chk(req, "cfg_valid per clock", 32'(cfg_valid),
             32'(exp_dn && (exp_rdy == 0 || it < exp_rdy)));
         chk(req, "host_ready per clock", 32'(host_ready), 32'(it == exp_rdy));
         if (cfg_valid && !seen_dn) begin
            seen_dn = 1;
            chk(req, "cfg_addr", cfg_addr, exp_addr);
            chk("R8", "cfg_be", 32'(cfg_be), 32'(ref_be(off, sz)));
            chk("R11", "cfg_write", 32'(cfg_write), 32'(wr));
            if (wr) chk("R11", "cfg_wdata", cfg_wdata, wd);
         end
         if (cfg_valid && exp_rdy == 0) begin
            if (cnt == lat) begin
               cfg_done = 1'b1; cfg_rdata = dn_data; exp_rdy = it + 1;
            end else cnt++;
         end
         if (host_ready || it == exp_rdy) begin
            chk(req, "host_rdata", host_rdata, exp_rd);
            chk(bad ? "R9" : req, "host_err", 32'(host_err), 32'(bad));
            host_valid = 1'b0;
            break;
         end
      end
      if (!win && wr && !bad)
         for (int i = 0; i < 4; i++) if (ref_be(off, sz)[i]) model_word[8*i +: 8] = wd[8*i +: 8];
   endtask

   initial begin
      #(8 * 200000);
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "ready at reset", 32'(host_ready), 32'd0);
      chk("R1", "cfg_valid at reset", 32'(cfg_valid), 32'd0);
      rst_n = 1'b1;
      access("R1", 0, 0, 0, 2'd2, 0, 0, 0);                     // word reads 0
      // R2: full write, byte write, readback
      access("R2", 0, 1, 0, 2'd2, 32'h1234_5678, 0, 0);
      access("R2", 0, 1, 2, 2'd0, 32'h00AB_0000, 0, 0);
      access("R2", 0, 0, 0, 2'd2, 0, 0, 0);
      access("R2", 0, 1, 1, 2'd1, 32'h00CD_EF00, 0, 0);
      access("R2", 0, 0, 4, 2'd2, 0, 0, 0);
      // R3: pass-through form with bit 0 set, offset 3 byte read
      access("R3", 0, 1, 0, 2'd2, 32'h8000_0805, 0, 0);
      access("R3", 1, 0, 3, 2'd0, 0, 0, 32'hDEAD_BEEF);
      access("R3", 1, 0, 2, 2'd1, 0, 2, 32'h1111_2222);
      // R4: type-1 form, 2-byte write at offset 6
      access("R4", 0, 1, 0, 2'd2, 32'h00AB_CDE5, 0, 0);
      access("R4", 1, 1, 6, 2'd1, 32'h5A5A_0000, 1, 0);
      access("R4", 1, 0, 1, 2'd0, 0, 0, 32'h0000_7700);
      // R5/R6: type-0, lowest select bit 11 with a higher stray bit
      access("R5", 0, 1, 0, 2'd2, 32'h0010_0B2C, 0, 0);
      access("R6", 1, 0, 4, 2'd2, 0, 0, 32'hCAFE_F00D);
      access("R5", 0, 1, 0, 2'd2, 32'h4000_0500, 0, 0);         // device 30
      access("R5", 1, 1, 0, 2'd2, 32'h0BAD_F00D, 3, 0);
      access("R6", 0, 1, 0, 2'd2, 32'h0002_07F8, 0, 0);         // device 17
      access("R6", 1, 0, 7, 2'd0, 0, 4, 32'h9900_0000);
      // R7: no select bit
      access("R7", 0, 1, 0, 2'd2, 32'h0000_07FC, 0, 0);
      access("R7", 1, 0, 0, 2'd2, 0, 0, 32'h1234_0000);
      access("R7", 1, 1, 4, 2'd1, 32'h0000_0000, 0, 0);
      // R9: illegal widths, word unchanged afterwards
      access("R9", 1, 0, 1, 2'd2, 0, 0, 0);
      access("R9", 1, 1, 3, 2'd1, 32'hFFFF_FFFF, 0, 0);
      access("R9", 0, 1, 0, 2'd3, 32'hFFFF_FFFF, 0, 0);
      access("R9", 0, 1, 2, 2'd2, 32'hFFFF_FFFF, 0, 0);
      access("R9", 0, 0, 0, 2'd2, 0, 0, 0);
      // R10: long downstream latency
      access("R10", 0, 1, 0, 2'd2, 32'h8000_1000, 0, 0);
      access("R10", 1, 0, 0, 2'd2, 0, 7, 32'h0F0F_0F0F);
      access("R11", 1, 1, 0, 2'd2, 32'hA5A5_C3C3, 5, 0);
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule